// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Character Queue

This block receives characters from a single non-return-to-zero serial line. An idle-high line falls to begin a start bit. The block confirms the start bit in the middle of that bit, then samples each data bit in its middle, least significant bit first, timed by an external tick that runs at sixteen times the bit rate. Each finished character goes into a two-entry queue. Every entry also stores its own framing-error bit and its ninth data bit.

The consumer watches `avail`. It reads `rd_data`, `rd_ninth` and `frame_err` for the oldest character, then pulses `pop` to remove that character. In 9-bit multidrop systems, the address filter drops every character whose ninth bit is 0. When a character completes while the queue is full, the block raises an overrun that stops all further reception. The consumer recovers by dropping `rx_en` for at least one cycle. Dropping `port_en` clears the entire receiver.

Top module: `async_rx_fifo2`

## Requirements
- R1: The block receives only when `port_en`=1, `rx_en`=1 and `sync_mode`=0. Otherwise line activity stores nothing and `rx_idle` stays 1.
- R2: A frame is one low start bit, then 8 data bits sent LSB first, then one stop bit, with 16 ticks per bit. When the frame ends, the character is stored, `avail` becomes 1 and `rd_data` shows the oldest stored character.
- R3: The queue returns characters in arrival order. `avail` returns to 0 once pops have removed every stored character.
- R4: The queue holds two characters. If a third character completes while it is full, `overrun` becomes 1, that character is discarded and the two stored characters stay readable.
- R5: While `overrun` is 1, no character is stored. `overrun` clears when `rx_en` or `port_en` is 0.
- R6: A stop bit sampled as 0 marks its character with `frame_err`=1. Reception continues afterwards, and `frame_err` follows the oldest entry, so it changes on `pop`.
- R7: `port_en`=0 empties the queue and clears `frame_err` and `overrun`.
- R8: With `nine_bit`=1, a ninth data bit follows the 8 data bits and comes before the stop bit. That ninth bit appears on `rd_ninth` for the oldest entry. In 8-bit mode `rd_ninth` reads 0.
- R9: With `addr_filter`=1, characters whose ninth bit is 0 are discarded, and characters whose ninth bit is 1 are stored.
- R10: `rx_idle` is 0 from start-bit detection until the frame ends, and 1 otherwise.
- R11: A low pulse on the line that is high again at the middle of the start bit (8 ticks after detection) is rejected. Nothing is stored and `rx_idle` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| port_en | input | 1 | Port enable; 0 resets the receiver |
| rx_en | input | 1 | Receive enable; 0 clears overrun |
| sync_mode | input | 1 | 1 selects synchronous mode; this block then stays idle |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| addr_filter | input | 1 | 1 keeps only characters whose ninth bit is 1 |
| rx_line | input | 1 | Serial input, idle high |
| pop | input | 1 | Removes the oldest character |
| avail | output | 1 | At least one character is stored |
| rd_data | output | 8 | Low byte of the oldest character |
| rd_ninth | output | 1 | Ninth bit of the oldest character |
| frame_err | output | 1 | Framing error of the oldest character |
| overrun | output | 1 | A character was lost because the queue was full |
| rx_idle | output | 1 | No frame in progress |

## Verification
The assertions assume that `sample_tick` is a single-cycle pulse and that `nine_bit` and `addr_filter` do not change while a frame is in progress. The stimulus generates the tick from a free-running divide-by-four counter. It changes modes only while the line has been idle for at least one bit time. It drives the line and `pop` on falling clock edges, so the checks never race the receiver's sampling edge. Each frame ends with a full high bit, which re-arms start detection even after a frame whose stop bit was low.

// File: rtl/async_rx_fifo2.sv
module async_rx_fifo2 #(
  parameter int TICKS = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_tick,
  input  logic          port_en,
  input  logic          rx_en,
  input  logic          sync_mode,
  input  logic          nine_bit,
  input  logic          addr_filter,
  input  logic          rx_line,
  input  logic          pop,
  output logic          avail,
  output logic [DW-1:0] rd_data,
  output logic          rd_ninth,
  output logic          frame_err,
  output logic          overrun,
  output logic          rx_idle
);
  localparam int CW   = $clog2(TICKS);
  localparam int HALF = TICKS / 2;
  localparam int BW   = $clog2(DW + 2);
  localparam int EW   = DW + 2;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  logic [1:0]    sync_q;
  st_t           st;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] bidx;
  logic [DW:0]   shreg;
  logic          armed;
  logic [EW-1:0] slot0, slot1;
  logic [1:0]    cnt;
  logic          ovr_q;

  wire line = sync_q[1];
  wire run  = port_en & rx_en & ~sync_mode;
  wire [BW-1:0] last_idx = nine_bit ? BW'(DW) : BW'(DW - 1);
  wire tick_end = (tcnt == CW'(TICKS - 1));

  wire          done    = run & sample_tick & (st == S_STOP) & tick_end;
  wire [DW-1:0] new_dat = nine_bit ? shreg[DW-1:0] : shreg[DW:1];
  wire          new_9th = nine_bit & shreg[DW];
  wire          accept  = done & ~(addr_filter & ~new_9th);
  wire          full    = (cnt == 2'd2);
  wire          push    = accept & ~full;
  wire          do_pop  = pop & (cnt != 2'd0);
  wire [1:0]    after_pop = cnt - {1'b0, do_pop};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_line};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tcnt <= '0; bidx <= '0; shreg <= '0; armed <= 1'b0;
    end else if (!run) begin
      st <= S_IDLE; tcnt <= '0; bidx <= '0; armed <= 1'b0;
    end else if (sample_tick) begin
      case (st)
        S_IDLE: begin
          armed <= line;
          if (armed && !line && !ovr_q) begin
            st <= S_START; tcnt <= '0;
          end
        end
        S_START:
          if (tcnt == CW'(HALF - 1)) begin
            tcnt <= '0; bidx <= '0;
            if (line) begin st <= S_IDLE; armed <= 1'b1; end
            else      st <= S_DATA;
          end else tcnt <= tcnt + 1'b1;
        S_DATA:
          if (tick_end) begin
            tcnt  <= '0;
            shreg <= {line, shreg[DW:1]};
            if (bidx == last_idx) st <= S_STOP;
            else                  bidx <= bidx + 1'b1;
          end else tcnt <= tcnt + 1'b1;
        default:
          if (tick_end) begin
            st <= S_IDLE; tcnt <= '0; armed <= 1'b0;
          end else tcnt <= tcnt + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0 <= '0; slot1 <= '0; cnt <= 2'd0; ovr_q <= 1'b0;
    end else if (!port_en) begin
      slot0 <= '0; slot1 <= '0; cnt <= 2'd0; ovr_q <= 1'b0;
    end else begin
      if (!rx_en)              ovr_q <= 1'b0;
      else if (accept && full) ovr_q <= 1'b1;
      if (do_pop) slot0 <= slot1;
      if (push) begin
        if (after_pop == 2'd0) slot0 <= {~line, new_9th, new_dat};
        else                   slot1 <= {~line, new_9th, new_dat};
      end
      cnt <= cnt + {1'b0, push} - {1'b0, do_pop};
    end
  end

  assign avail     = (cnt != 2'd0);
  assign rd_data   = slot0[DW-1:0];
  assign rd_ninth  = slot0[DW];
  assign frame_err = slot0[DW+1] & avail;
  assign overrun   = ovr_q;
  assign rx_idle   = (st == S_IDLE);
endmodule

// File: rtl/async_rx_fifo2_checks.sv
module async_rx_fifo2_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       port_en,
  input logic       rx_en,
  input logic       sync_mode,
  input logic       avail,
  input logic       frame_err,
  input logic       overrun,
  input logic       rx_idle,
  input logic [1:0] cnt
);
  p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_en && rx_en && !sync_mode) |=> rx_idle);

  p_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 2'd2);

  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && rx_en && port_en) |=> overrun);

  p_ovr_nopush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> cnt <= $past(cnt));

  p_ovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !overrun);

  p_ferr_has_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> avail);

  p_port_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!avail && !overrun && !frame_err));
endmodule

bind async_rx_fifo2 async_rx_fifo2_checks u_checks (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .rx_en(rx_en),
  .sync_mode(sync_mode), .avail(avail), .frame_err(frame_err),
  .overrun(overrun), .rx_idle(rx_idle), .cnt(cnt)
);

// File: tb/tb_async_rx_fifo2.sv
module tb_async_rx_fifo2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic port_en = 1'b1, rx_en = 1'b1, sync_mode = 1'b0;
  logic nine_bit = 1'b0, addr_filter = 1'b0, rx_line = 1'b1, pop = 1'b0;
  logic avail, rd_ninth, frame_err, overrun, rx_idle;
  logic [7:0] rd_data;
  logic [1:0] dv = 2'd0;
  logic tick;
  int errs = 0, checks = 0;

  always #5 clk = ~clk;
  always_ff @(posedge clk) dv <= dv + 2'd1;
  assign tick = (dv == 2'd3);

  async_rx_fifo2 dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .port_en(port_en),
    .rx_en(rx_en), .sync_mode(sync_mode), .nine_bit(nine_bit),
    .addr_filter(addr_filter), .rx_line(rx_line), .pop(pop),
    .avail(avail), .rd_data(rd_data), .rd_ninth(rd_ninth),
    .frame_err(frame_err), .overrun(overrun), .rx_idle(rx_idle)
  );

  // {nine, addr, data9, stop, stored, ferr}
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 1'b0, 9'h0A5, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b0, 9'h03C, 1'b0, 1'b1, 1'b1},
    {1'b1, 1'b0, 9'h15A, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b0, 9'h081, 1'b1, 1'b1, 1'b0},
    {1'b1, 1'b1, 9'h077, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b1, 9'h142, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b0, 9'h000, 1'b1, 1'b1, 1'b0},
    {1'b0, 1'b0, 9'h0FF, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk); rx_line = b;
    repeat (63) @(negedge clk);
  endtask

  task automatic send(input logic n9, input logic [8:0] d, input logic stopb);
    bit_out(1'b0);
    for (int i = 0; i < 8; i++) bit_out(d[i]);
    if (n9) bit_out(d[8]);
    bit_out(stopb);
    bit_out(1'b1);
  endtask

  task automatic do_pop();
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (70) @(negedge clk);
    chk(!avail && !overrun && !frame_err && rx_idle, "reset R7 R10", {avail, overrun, frame_err, rx_idle}, 4'b0001);

    // Vector table: R2 R6 R8 R9
    for (int v = 0; v < 8; v++) begin
      nine_bit = VEC[v][13]; addr_filter = VEC[v][12];
      repeat (70) @(negedge clk);
      send(VEC[v][13], VEC[v][11:3], VEC[v][2]);
      chk(avail == VEC[v][1], "R2 R9 stored", avail, VEC[v][1]);
      if (VEC[v][1]) begin
        chk(rd_data == VEC[v][10:3], "R2 data", rd_data, VEC[v][10:3]);
        chk(rd_ninth == (VEC[v][13] & VEC[v][11]), "R8 ninth", rd_ninth, VEC[v][13] & VEC[v][11]);
        chk(frame_err == VEC[v][0], "R6 ferr", frame_err, VEC[v][0]);
        do_pop();
        chk(!avail, "R3 empty after pop", avail, 0);
      end
    end
    nine_bit = 1'b0; addr_filter = 1'b0;
    repeat (70) @(negedge clk);

    // R3 ordering
    send(1'b0, 9'h011, 1'b1);
    send(1'b0, 9'h022, 1'b1);
    chk(avail && rd_data == 8'h11, "R3 first", rd_data, 8'h11);
    do_pop();
    chk(avail && rd_data == 8'h22, "R3 second", rd_data, 8'h22);
    do_pop();
    chk(!avail, "R3 avail cleared", avail, 0);

    // R6 ferr then good frame, ferr moves with pop
    send(1'b0, 9'h0E1, 1'b0);
    send(1'b0, 9'h0E2, 1'b1);
    chk(frame_err && rd_data == 8'hE1, "R6 head ferr", frame_err, 1);
    do_pop();
    chk(!frame_err && avail && rd_data == 8'hE2, "R6 ferr after pop", frame_err, 0);
    do_pop();

    // R4 R5 overrun
    send(1'b0, 9'h031, 1'b1);
    send(1'b0, 9'h032, 1'b1);
    send(1'b0, 9'h033, 1'b1);
    chk(overrun, "R4 overrun set", overrun, 1);
    chk(rd_data == 8'h31, "R4 head kept", rd_data, 8'h31);
    do_pop();
    chk(rd_data == 8'h32, "R4 second kept", rd_data, 8'h32);
    do_pop();
    send(1'b0, 9'h034, 1'b1);
    chk(!avail && overrun, "R5 locked out", {avail, overrun}, 2'b01);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    chk(!overrun, "R5 cleared by rx_en", overrun, 0);
    repeat (70) @(negedge clk);
    send(1'b0, 9'h035, 1'b1);
    chk(avail && rd_data == 8'h35, "R5 receives again", rd_data, 8'h35);
    do_pop();

    // R7 port disable
    send(1'b0, 9'h0BE, 1'b0);
    chk(avail && frame_err, "R7 setup", {avail, frame_err}, 2'b11);
    @(negedge clk); port_en = 1'b0;
    @(negedge clk);
    chk(!avail && !frame_err && !overrun, "R7 cleared", {avail, frame_err}, 0);
    port_en = 1'b1;
    repeat (70) @(negedge clk);

    // R1 disabled modes
    rx_en = 1'b0;
    send(1'b0, 9'h055, 1'b1);
    chk(!avail && rx_idle, "R1 rx_en off", avail, 0);
    rx_en = 1'b1; sync_mode = 1'b1;
    send(1'b0, 9'h056, 1'b1);
    chk(!avail && rx_idle, "R1 sync mode", avail, 0);
    sync_mode = 1'b0;
    repeat (70) @(negedge clk);

    // R10 idle flag
    bit_out(1'b0);
    chk(!rx_idle, "R10 busy in frame", rx_idle, 0);
    for (int i = 0; i < 8; i++) bit_out(1'b1);
    bit_out(1'b1);
    bit_out(1'b1);
    chk(rx_idle && avail && rd_data == 8'hFF, "R10 idle after frame", rx_idle, 1);
    do_pop();

    // R11 glitch
    @(negedge clk); rx_line = 1'b0;
    repeat (16) @(negedge clk);
    rx_line = 1'b1;
    repeat (128) @(negedge clk);
    chk(rx_idle && !avail, "R11 glitch rejected", {rx_idle, avail}, 2'b10);

    finish_run();
  end
endmodule